// File: doc/BRIEF.md
# Dual-Policy Cache Victim Selector

This block holds the replacement state for every set of an N-way set-associative cache. On a miss it names the way to evict. A static policy input picks one of two schemes. The first is a one-bit-per-way not-recently-used scheme with a pseudo-random tie-break. The second is a two-bit saturating re-reference counter per way. The counter scheme separates blocks that are touched once, such as streaming data, from blocks that are reused. The cache controller reports hits, misses and line fills on a single shared access port. It reads back the chosen victim together with a one-cycle strobe. Tags and data live elsewhere.

Each set's state is one row of `2*WAYS` bits, holding a two-bit field per way. In the one-bit scheme only the low bit of each field is used, and a set bit marks a way as a replacement candidate ("stale"). A miss in the one-bit scheme always resolves at the next clock edge. A miss in the counter scheme may first age the set over several clocks. During that time the controller waits for the strobe and issues no other request.

Top module: `repl_victim_sel`

## Requirements
- R1: After reset, `victim_valid` and `victim_way` are 0, and every state field of every set is 0.
- R2: In stale-bit mode (`policy_sel`=0), a hit (`acc_valid`=1, `acc_hit`=1) clears the stale bit of way `acc_way` in set `acc_set` and changes no other way.
- R3: In stale-bit mode, a miss (`acc_valid`=1, `acc_hit`=0) on a set where some, but not all, ways are stale picks the lowest-numbered stale way and clears every stale bit of that set. `victim_valid` is high in the cycle after the miss is sampled.
- R4: In stale-bit mode, a miss on a set where all ways are stale, or where no way is stale, picks way `lfsr[WAY_W-1:0]`. `lfsr` is the generator value at the sampling edge. If all ways were stale, every bit of the set is cleared. If none was stale, every bit of the set is set.
- R5: The generator is a 16-bit shift register. Reset loads it with 16'hACE1. On every other clock it becomes `{q[14:0], q[15]^q[13]^q[12]^q[10]}`. It never holds 0.
- R6: In counter mode (`policy_sel`=1), a hit sets the counter of way `acc_way` to 0.
- R7: In counter mode, a miss on a set that has a counter at 3 picks the lowest-numbered such way. `victim_valid` rises in the cycle after the miss is sampled, and no counter changes.
- R8: In counter mode, a miss on a set with no counter at 3 increments every counter of the set once per clock until one reaches 3. The victim is then the lowest way at 3, delivered 3 - max clocks later than under R7, where max is the largest counter before the miss.
- R9: A fill (`fill_req`=1) writes way `acc_way` of set `acc_set`. It sets that way's counter to 2 in counter mode and clears its stale bit in stale-bit mode.
- R10: `victim_valid` rises only in response to a miss. It lasts one cycle per miss, and `victim_way` holds the chosen way while it is high.
- R11: When `fill_req` and `acc_valid` are high together, only the fill takes effect and the access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 1 | 0 = stale-bit scheme, 1 = two-bit counter scheme; held static |
| acc_valid | input | 1 | Access report valid |
| acc_set | input | SET_W | Set index for access or fill |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | WAY_W | Hit way, or way being filled |
| fill_req | input | 1 | Line fill of `acc_way` in `acc_set` |
| victim_valid | output | 1 | One-cycle strobe: victim chosen |
| victim_way | output | WAY_W | Chosen victim way |

## Verification
Misses are issued against sets whose state the bench has steered into each selection case. In stale-bit mode these are partly stale, fully stale and fully fresh sets, which separate the lowest-way pick from the generator pick and show which way the row is rewritten. In counter mode the bench first misses on an all-zero set to expose the full three-clock aging delay. It then misses on sets that already hold a 3 and on sets whose maximum is 1 or 2, which distinguishes immediate selection from aging by the right number of steps. Seeded random mixes of hits, fills and misses over a few shared sets, including fills that coincide with hits, exercise the way-isolation and priority rules against a reference model.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef enum logic {POL_NRU = 1'b0, POL_RRC = 1'b1} policy_e;

  localparam logic [1:0] RRC_MAX  = 2'd3;
  localparam logic [1:0] RRC_FILL = 2'd2;
  localparam int         RND_W    = 16;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

  // Fibonacci step, taps 16/14/13/11
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr
  import rvs_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = RND_SEED
) (
  input  logic             clk,
  input  logic             rst,
  output logic [RND_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= rnd_step(q);
  end

  // A zero state would lock the generator
  assert_rnd_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    q != '0);
endmodule

// File: rtl/rvs_lowest.sv
module rvs_lowest #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/rvs_row_eval.sv
module rvs_row_eval
  import rvs_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ROW_W = 2 * WAYS
) (
  input  policy_e          policy,
  input  logic [ROW_W-1:0] row,
  output logic             cand_any,
  output logic             cand_all,
  output logic [WAY_W-1:0] cand_idx,
  output logic [ROW_W-1:0] aged_row
);
  logic [WAYS-1:0] cand;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [1:0] fld;
    assign fld = row[2*w +: 2];
    assign cand[w] = (policy == POL_RRC) ? (fld == RRC_MAX) : fld[0];
    assign aged_row[2*w +: 2] = (fld == RRC_MAX) ? RRC_MAX : fld + 2'd1;
  end

  assign cand_all = &cand;

  rvs_lowest #(.N(WAYS)) u_pick (
    .req  (cand),
    .found(cand_any),
    .idx  (cand_idx)
  );
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel
  import rvs_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int ROW_W = 2 * WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             policy_sel,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fill_req,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  policy_e policy;
  assign policy = policy_e'(policy_sel);

  logic [ROW_W-1:0] state_mem [SETS];
  logic             aging_q;
  logic [SET_W-1:0] hold_set_q;
  logic [RND_W-1:0] rnd;

  logic [SET_W-1:0] cur_set;
  logic [ROW_W-1:0] cur_row;
  logic             cand_any, cand_all;
  logic [WAY_W-1:0] cand_idx;
  logic [ROW_W-1:0] aged_row;

  logic             we;
  logic [ROW_W-1:0] wr_row;
  logic             take, age_start, age_end;
  logic [WAY_W-1:0] take_way;

  assign cur_set = aging_q ? hold_set_q : acc_set;
  assign cur_row = state_mem[cur_set];

  rvs_lfsr u_rnd (
    .clk(clk),
    .rst(rst),
    .q  (rnd)
  );

  rvs_row_eval #(.WAYS(WAYS)) u_eval (
    .policy  (policy),
    .row     (cur_row),
    .cand_any(cand_any),
    .cand_all(cand_all),
    .cand_idx(cand_idx),
    .aged_row(aged_row)
  );

  function automatic logic [ROW_W-1:0] put_field(input logic [ROW_W-1:0] r,
                                                 input logic [WAY_W-1:0] w,
                                                 input logic [1:0] v);
    logic [ROW_W-1:0] o;
    o = r;
    for (int i = 0; i < WAYS; i++) begin
      if (w == WAY_W'(i)) o[2*i +: 2] = v;
    end
    return o;
  endfunction

  always_comb begin
    we        = 1'b0;
    wr_row    = cur_row;
    take      = 1'b0;
    take_way  = '0;
    age_start = 1'b0;
    age_end   = 1'b0;
    if (aging_q) begin
      if (cand_any) begin
        take     = 1'b1;
        take_way = cand_idx;
        age_end  = 1'b1;
      end else begin
        we     = 1'b1;
        wr_row = aged_row;
      end
    end else if (fill_req) begin
      we     = 1'b1;
      wr_row = put_field(cur_row, acc_way,
                         (policy == POL_RRC) ? RRC_FILL : 2'd0);
    end else if (acc_valid && acc_hit) begin
      we     = 1'b1;
      wr_row = put_field(cur_row, acc_way, 2'd0);
    end else if (acc_valid) begin
      if (policy == POL_NRU) begin
        take = 1'b1;
        we   = 1'b1;
        if (cand_any && !cand_all) begin
          take_way = cand_idx;
          wr_row   = '0;
        end else begin
          take_way = rnd[WAY_W-1:0];
          wr_row   = cand_any ? '0 : {WAYS{2'b01}};
        end
      end else if (cand_any) begin
        take     = 1'b1;
        take_way = cand_idx;
      end else begin
        we        = 1'b1;
        wr_row    = aged_row;
        age_start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) state_mem[s] <= '0;
      aging_q      <= 1'b0;
      hold_set_q   <= '0;
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      if (we) state_mem[cur_set] <= wr_row;
      victim_valid <= take;
      if (take) victim_way <= take_way;
      if (age_start) begin
        aging_q    <= 1'b1;
        hold_set_q <= acc_set;
      end else if (age_end) begin
        aging_q <= 1'b0;
      end
    end
  end

  function automatic logic [1:0] get_field(input logic [ROW_W-1:0] r,
                                           input logic [WAY_W-1:0] w);
    return r[{w, 1'b0} +: 2];
  endfunction

  assert_hit_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!aging_q && !fill_req && acc_valid && acc_hit && policy == POL_RRC) |=>
      get_field(state_mem[$past(acc_set)], $past(acc_way)) == 2'd0);

  assert_fill_value_R9: assert property (@(posedge clk) disable iff (rst)
    (!aging_q && fill_req) |=>
      get_field(state_mem[$past(acc_set)], $past(acc_way)) ==
        ((policy == POL_RRC) ? RRC_FILL : 2'd0));

  assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> $past(aging_q || (acc_valid && !acc_hit && !fill_req)));

  assert_aging_counter_only_R8: assert property (@(posedge clk) disable iff (rst)
    aging_q |-> policy == POL_RRC);
endmodule

// File: tb/repl_victim_sel_test.sv
module repl_victim_sel_test;
  localparam int WAYS = 8;
  localparam int SETS = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       policy_sel = 1'b0;
  logic       acc_valid = 1'b0;
  logic [4:0] acc_set = '0;
  logic       acc_hit = 1'b0;
  logic [2:0] acc_way = '0;
  logic       fill_req = 1'b0;
  logic       victim_valid;
  logic [2:0] victim_way;

  int errors = 0;
  int checks = 0;
  int mdl [SETS][WAYS];
  logic [15:0] blfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  repl_victim_sel #(.WAYS(WAYS), .SETS(SETS)) uut (
    .clk(clk), .rst(rst), .policy_sel(policy_sel),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_hit(acc_hit),
    .acc_way(acc_way), .fill_req(fill_req),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  always @(posedge clk)
    blfsr <= rst ? 16'hACE1 : {blfsr[14:0], blfsr[15]^blfsr[13]^blfsr[12]^blfsr[10]};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst = 1'b1; policy_sel = pol;
    acc_valid = 0; fill_req = 0; acc_hit = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) mdl[s][w] = 0;
    @(negedge clk);
    check("R1 valid after reset", victim_valid, 0);
    check("R1 way after reset", victim_way, 0);
  endtask

  task automatic do_hit(input int s, input int w);
    @(negedge clk);
    acc_valid = 1; acc_hit = 1; acc_set = 5'(s); acc_way = 3'(w);
    @(negedge clk);
    acc_valid = 0;
    mdl[s][w] = 0;                       // R2 / R6
  endtask

  task automatic do_fill(input int s, input int w, input bit with_hit);
    @(negedge clk);
    fill_req = 1; acc_set = 5'(s); acc_way = 3'(w);
    acc_valid = with_hit; acc_hit = 1;
    @(negedge clk);
    fill_req = 0; acc_valid = 0;
    mdl[s][w] = policy_sel ? 2 : 0;      // R9, R11: hit ignored
  endtask

  task automatic do_miss(input int s, input string tag);
    int v, k, lat;
    bit any, all, got;
    @(negedge clk);
    acc_valid = 1; acc_hit = 0; acc_set = 5'(s);
    v = -1; k = 0;
    if (!policy_sel) begin
      any = 0; all = 1;
      for (int w = WAYS - 1; w >= 0; w--)
        if (mdl[s][w] != 0) begin any = 1; v = w; end else all = 0;
      if (!(any && !all)) v = int'(blfsr[2:0]);
      for (int w = 0; w < WAYS; w++) mdl[s][w] = (any || all) ? 0 : 1;
      if (!any) for (int w = 0; w < WAYS; w++) mdl[s][w] = 1;
    end else begin
      forever begin
        for (int w = WAYS - 1; w >= 0; w--) if (mdl[s][w] == 3) v = w;
        if (v >= 0) break;
        for (int w = 0; w < WAYS; w++) mdl[s][w]++;
        k++;
      end
    end
    @(negedge clk);
    acc_valid = 0;
    lat = 0; got = 0;
    for (int i = 0; i < 8; i++) begin
      if (victim_valid) begin got = 1; break; end
      lat++;
      @(negedge clk);
    end
    check({tag, " strobe seen"}, got, 1);
    check({tag, " latency"}, lat, k);
    check({tag, " victim way"}, victim_way, v);
    @(negedge clk);
    check("R10 strobe one cycle", victim_valid, 0);
  endtask

  task automatic random_ops(input int n);
    int sets [4] = '{0, 1, 2, 31};
    for (int i = 0; i < n; i++) begin
      int op, s, w;
      op = $urandom_range(0, 9);
      s = sets[$urandom_range(0, 3)];
      w = $urandom_range(0, WAYS - 1);
      if (op < 4) do_hit(s, w);
      else if (op < 6) do_fill(s, w, 0);
      else if (op < 7) do_fill(s, w, 1);
      else do_miss(s, policy_sel ? "R7/R8 random" : "R3/R4 random");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // stale-bit scheme
    do_reset(1'b0);
    do_miss(3, "R4 none stale");          // all bits become set
    do_miss(3, "R4 all stale");           // all cleared
    do_miss(3, "R4 none stale again");
    do_hit(3, 0);                         // R2 clears way 0 only
    do_hit(3, 2);
    do_miss(3, "R2/R3 lowest stale");     // expects way 1
    do_miss(4, "R4 none stale");
    do_fill(4, 0, 0);                     // R9 clears way 0
    do_miss(4, "R9/R3 after fill");       // expects way 1
    random_ops(150);
    // counter scheme
    do_reset(1'b1);
    do_miss(5, "R8 from zero");           // 3 aging steps, way 0
    do_fill(5, 0, 0);                     // counter 2
    do_miss(5, "R7 immediate");           // way 1
    do_hit(5, 1);
    do_hit(5, 2);
    do_fill(5, 3, 1);                     // R11: fill wins, counter 2
    for (int w = 4; w < WAYS; w++) do_hit(5, w);
    do_miss(5, "R6/R11/R8 one step");     // way 0 or 3 at 3 after one step
    do_miss(6, "R8 from zero");
    for (int w = 0; w < WAYS; w++) do_hit(6, w);
    do_fill(6, 6, 0);
    do_miss(6, "R8 max two");
    random_ops(150);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule